// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Controller

This block decides which interrupt request a small processor core takes next. Five fixed sources (a reset request, a non-maskable interrupt, a watchdog interrupt, a single-step trap and an address-match trap) and `NUM_PER` peripheral request lines are each caught in a pending latch. Each peripheral also carries a 3-bit priority level that software writes. The block holds the processor interrupt priority level (`ipl`) and the interrupt enable flag (`ien`). When a pending request is allowed to win, the block gives a one-cycle acknowledge that carries the source index and a vector number. It then clears that source's pending bit, clears `ien` and loads `ipl` with the level of the accepted source.

Three sources ignore `ien` and `ipl`: the reset request, the NMI and the watchdog. A peripheral is taken only while `ien` is 1 and its level is strictly above `ipl`. Among peripherals, a higher level wins. At equal level the request that has waited longest wins, and the lower line index breaks any tie that remains. The two traps need only `ien`, and they rank below every peripheral. A peripheral that loses because its level is too low stays pending. The `rti_load` input models a return from interrupt: it reloads `ipl` and `ien`, and the pending requests are then weighed again.

A three-state machine paces acknowledges. In `ST_IDLE` the winner is registered, and the transition IDLE→ACK is taken whenever a winner exists. In `ST_ACK` the acknowledge is driven, and the transition ACK→SETTLE is taken unconditionally; at that edge the pending bit is cleared and `ipl`/`ien` are rewritten. `ST_SETTLE` is a gap cycle, and the transition SETTLE→IDLE is taken unconditionally.

Top module: `irq_arbiter`

## Requirements
- R1: Each fixed source request is latched on the clock edge where its input is high. It stays pending until that source is acknowledged.
- R2: Among requests that are eligible together, the rank is: reset request, then NMI, then watchdog, then any peripheral, then single-step, then address match.
- R3: Among eligible peripherals, the one with the highest programmed level (`per_level[3i+2:3i]` for line i) wins.
- R4: Among eligible peripherals of equal level, the one whose request was latched earliest wins. Requests latched in the same cycle go to the lower line index.
- R5: A peripheral is eligible only while `ien`=1 and its level is strictly greater than `ipl`. Single-step and address match are eligible only while `ien`=1.
- R6: The reset request, NMI and watchdog are eligible whatever the values of `ien` and `ipl`.
- R7: The acknowledge is a one-cycle pulse on `ack_valid`. `ack_src` follows this encoding: 0 reset, 1 NMI, 2 watchdog, 3 single-step, 4 address match, 5+i peripheral i. `ack_vec` equals `VEC_BASE`+`ack_src`. From an idle block, the pulse appears in the cycle after the edge that follows the latching edge. At least two cycles without an acknowledge separate two pulses.
- R8: At the edge that ends the acknowledge, `ien` becomes 0 and `ipl` takes the accepted level. That level is the programmed level for a peripheral, 7 for NMI, watchdog, single-step and address match, and 0 for the reset request.
- R9: A peripheral request refused because of its level stays pending. It is acknowledged once a restore lowers `ipl` below its level.
- R10: `rti_load` loads `ipl` from `rti_ipl` and `ien` from `rti_ien` at the next edge. At the edge that ends an acknowledge, the acknowledge update takes precedence over the restore.
- R11: A peripheral whose level is 0 does not latch its request, so that request is never acknowledged, even if the level is raised afterwards.
- R12: While `rst_n` is low, all pending bits clear, `ipl` and `ien` become 0 and no acknowledge is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_irq | input | 1 | Reset interrupt request |
| nmi_irq | input | 1 | Non-maskable interrupt request |
| wdt_irq | input | 1 | Watchdog interrupt request |
| step_irq | input | 1 | Single-step trap request |
| amatch_irq | input | 1 | Address-match trap request |
| per_irq | input | NUM_PER | Peripheral request lines |
| per_level | input | NUM_PER*3 | Programmed level per peripheral, line i at bits 3i+2:3i |
| rti_load | input | 1 | Restore strobe (return from interrupt) |
| rti_ipl | input | 3 | Level to restore |
| rti_ien | input | 1 | Enable flag to restore |
| ack_valid | output | 1 | One-cycle acknowledge |
| ack_src | output | SRC_W | Index of the acknowledged source |
| ack_vec | output | VEC_W | Vector number of the acknowledged source |
| ipl | output | 3 | Processor interrupt priority level |
| ien | output | 1 | Interrupt enable flag |

## Verification
A request latched at edge e0 is arbitrated in the cycle after it. The acknowledge is then visible after edge e1, and the new `ipl` and `ien` after edge e2. A restore driven before edge E shows up on `ipl`/`ien` after E, and it lets a held request be acknowledged after E+1. The bench drives inputs just after falling edges and samples at the falling edge that exactly matches these counts. It also confirms that nothing is acknowledged in the gap cycles and in the cycles where a request must be refused.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W     = 3;
    localparam int NUM_FIXED = 5;
    localparam logic [LVL_W-1:0] LVL_TOP = '1;

    // fixed source indices, in hardware rank order
    localparam int SRC_RESET  = 0;
    localparam int SRC_NMI    = 1;
    localparam int SRC_WDT    = 2;
    localparam int SRC_STEP   = 3;
    localparam int SRC_AMATCH = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACK    = 2'd1,
        ST_SETTLE = 2'd2
    } arb_state_t;
endpackage

// File: rtl/irq_req_slot.sv
module irq_req_slot
    import irq_arb_pkg::*;
#(
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic [LVL_W-1:0] level,
    input  logic             clr,
    output logic             pend,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic req_ok;
    assign req_ok = req_in && (level != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            age  <= '0;
        end else if (req_ok) begin
            pend <= 1'b1;
            if (!pend || clr)
                age <= '0;
            else if (age != AGE_MAX)
                age <= age + 1'b1;
        end else if (clr) begin
            pend <= 1'b0;
            age  <= '0;
        end else if (pend && (age != AGE_MAX)) begin
            age <= age + 1'b1;
        end
    end

    AST_ZERO_LEVEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && level == '0) |=> !pend); // R11
    AST_FRESH_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> age == '0); // R4
endmodule

// File: rtl/irq_winner.sv
module irq_winner
    import irq_arb_pkg::*;
#(
    parameter int NUM_PER = 4,
    parameter int AGE_W   = 4,
    parameter int SRC_W   = 4
) (
    input  logic [NUM_PER-1:0]       per_pend,
    input  logic [NUM_PER*LVL_W-1:0] per_lvl,
    input  logic [NUM_PER*AGE_W-1:0] per_age,
    input  logic [NUM_FIXED-1:0]     fix_pend,
    input  logic [LVL_W-1:0]         ipl,
    input  logic                     ien,
    output logic                     win_valid,
    output logic [SRC_W-1:0]         win_src,
    output logic [LVL_W-1:0]         win_lvl
);
    logic                   best_ok;
    logic [SRC_W-1:0]       best_src;
    logic [LVL_W-1:0]       best_lvl;
    logic [LVL_W+AGE_W-1:0] best_key;
    logic [LVL_W+AGE_W-1:0] cand_key;
    logic                   cand_ok;

    // peripheral contest: level first, then age, then lowest index
    always_comb begin
        best_ok  = 1'b0;
        best_src = '0;
        best_lvl = '0;
        best_key = '0;
        cand_key = '0;
        cand_ok  = 1'b0;
        for (int i = 0; i < NUM_PER; i++) begin
            cand_ok  = per_pend[i] && ien && (per_lvl[i*LVL_W +: LVL_W] > ipl);
            cand_key = {per_lvl[i*LVL_W +: LVL_W], per_age[i*AGE_W +: AGE_W]};
            if (cand_ok && (!best_ok || cand_key > best_key)) begin
                best_ok  = 1'b1;
                best_key = cand_key;
                best_lvl = per_lvl[i*LVL_W +: LVL_W];
                best_src = SRC_W'(NUM_FIXED + i);
            end
        end
    end

    // fixed hardware rank around the peripheral group
    always_comb begin
        win_valid = 1'b1;
        win_src   = '0;
        win_lvl   = LVL_TOP;
        if (fix_pend[SRC_RESET]) begin
            win_src = SRC_W'(SRC_RESET);
            win_lvl = '0;
        end else if (fix_pend[SRC_NMI]) begin
            win_src = SRC_W'(SRC_NMI);
        end else if (fix_pend[SRC_WDT]) begin
            win_src = SRC_W'(SRC_WDT);
        end else if (best_ok) begin
            win_src = best_src;
            win_lvl = best_lvl;
        end else if (ien && fix_pend[SRC_STEP]) begin
            win_src = SRC_W'(SRC_STEP);
        end else if (ien && fix_pend[SRC_AMATCH]) begin
            win_src = SRC_W'(SRC_AMATCH);
        end else begin
            win_valid = 1'b0;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_PER = 4,
    parameter int AGE_W   = 4,
    parameter int VEC_W   = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h20,
    localparam int SRC_W = $clog2(NUM_PER + NUM_FIXED)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rst_irq,
    input  logic                     nmi_irq,
    input  logic                     wdt_irq,
    input  logic                     step_irq,
    input  logic                     amatch_irq,
    input  logic [NUM_PER-1:0]       per_irq,
    input  logic [NUM_PER*LVL_W-1:0] per_level,
    input  logic                     rti_load,
    input  logic [LVL_W-1:0]         rti_ipl,
    input  logic                     rti_ien,
    output logic                     ack_valid,
    output logic [SRC_W-1:0]         ack_src,
    output logic [VEC_W-1:0]         ack_vec,
    output logic [LVL_W-1:0]         ipl,
    output logic                     ien
);
    arb_state_t state_q, state_d;

    logic [SRC_W-1:0]       win_src_q;
    logic [LVL_W-1:0]       win_lvl_q;
    logic [LVL_W-1:0]       ipl_q;
    logic                   ien_q;
    logic [NUM_FIXED-1:0]   fix_pend;
    logic [NUM_FIXED-1:0]   fix_req;
    logic [NUM_FIXED-1:0]   fix_clr;
    logic [NUM_PER-1:0]     per_pend;
    logic [NUM_PER-1:0]     per_clr;
    logic [NUM_PER*AGE_W-1:0] per_age;
    logic                   win_valid;
    logic [SRC_W-1:0]       win_src;
    logic [LVL_W-1:0]       win_lvl;
    logic                   ack_edge;

    assign ack_edge = (state_q == ST_ACK);
    assign fix_req  = {amatch_irq, step_irq, wdt_irq, nmi_irq, rst_irq};

    // fixed-source pending latches; a new request wins over a clear
    generate
        for (genvar f = 0; f < NUM_FIXED; f++) begin : g_fix
            assign fix_clr[f] = ack_edge && (win_src_q == SRC_W'(f));
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fix_pend[f] <= 1'b0;
                else if (fix_req[f])
                    fix_pend[f] <= 1'b1;
                else if (fix_clr[f])
                    fix_pend[f] <= 1'b0;
            end
        end
    endgenerate

    // peripheral pending latches with arrival age
    generate
        for (genvar p = 0; p < NUM_PER; p++) begin : g_per
            assign per_clr[p] = ack_edge && (win_src_q == SRC_W'(NUM_FIXED + p));
            irq_req_slot #(
                .AGE_W (AGE_W)
            ) i_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_in (per_irq[p]),
                .level  (per_level[p*LVL_W +: LVL_W]),
                .clr    (per_clr[p]),
                .pend   (per_pend[p]),
                .age    (per_age[p*AGE_W +: AGE_W])
            );
        end
    endgenerate

    irq_winner #(
        .NUM_PER (NUM_PER),
        .AGE_W   (AGE_W),
        .SRC_W   (SRC_W)
    ) i_winner (
        .per_pend  (per_pend),
        .per_lvl   (per_level),
        .per_age   (per_age),
        .fix_pend  (fix_pend),
        .ipl       (ipl_q),
        .ien       (ien_q),
        .win_valid (win_valid),
        .win_src   (win_src),
        .win_lvl   (win_lvl)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_valid) state_d = ST_ACK;
            ST_ACK:    state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // winner capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_src_q <= '0;
            win_lvl_q <= '0;
        end else if (state_q == ST_IDLE && win_valid) begin
            win_src_q <= win_src;
            win_lvl_q <= win_lvl;
        end
    end

    // processor level and enable flag; acknowledge beats restore
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl_q <= '0;
            ien_q <= 1'b0;
        end else if (ack_edge) begin
            ipl_q <= win_lvl_q;
            ien_q <= 1'b0;
        end else if (rti_load) begin
            ipl_q <= rti_ipl;
            ien_q <= rti_ien;
        end
    end

    // outputs
    always_comb begin
        ack_valid = (state_q == ST_ACK);
        ack_src   = ack_valid ? win_src_q : '0;
        ack_vec   = ack_valid ? (VEC_BASE + VEC_W'(win_src_q)) : '0;
        ipl       = ipl_q;
        ien       = ien_q;
    end

    AST_ACK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid ##1 !ack_valid); // R7
    AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ien); // R8
    AST_RESET_SRC_ZERO_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_src == SRC_W'(SRC_RESET)) |=> ipl == '0); // R8
    AST_PER_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && win_valid && win_src >= SRC_W'(NUM_FIXED))
            |-> (ien && win_lvl > ipl)); // R5
    AST_NONMASK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (fix_pend[SRC_RESET] || fix_pend[SRC_NMI] || fix_pend[SRC_WDT]))
            |=> ack_valid); // R6
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PER = 4;
    localparam int SRC_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_irq = 1'b0, nmi_irq = 1'b0, wdt_irq = 1'b0, step_irq = 1'b0, amatch_irq = 1'b0;
    logic [NUM_PER-1:0] per_irq = '0;
    logic [NUM_PER*3-1:0] per_level = '0;
    logic rti_load = 1'b0;
    logic [2:0] rti_ipl = '0;
    logic rti_ien = 1'b0;
    logic ack_valid;
    logic [SRC_W-1:0] ack_src;
    logic [7:0] ack_vec;
    logic [2:0] ipl;
    logic ien;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter i_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .rst_irq(rst_irq), .nmi_irq(nmi_irq),
        .wdt_irq(wdt_irq), .step_irq(step_irq), .amatch_irq(amatch_irq),
        .per_irq(per_irq), .per_level(per_level), .rti_load(rti_load),
        .rti_ipl(rti_ipl), .rti_ien(rti_ien), .ack_valid(ack_valid),
        .ack_src(ack_src), .ack_vec(ack_vec), .ipl(ipl), .ien(ien)
    );

    // fields: [32:30] ipl, [29] ien, [28:24] {rst,nmi,wdt,step,amatch},
    // [23:20] peripheral lines, [19:8] levels {l3,l2,l1,l0},
    // [7] ack expected, [6:3] source expected, [2:0] ipl expected after
    localparam int NVEC = 14;
    localparam logic [32:0] VEC_TBL [NVEC] = '{
        {3'd0,1'b1,5'b00000,4'b0001,3'd0,3'd0,3'd0,3'd2,1'b1,4'd5,3'd2},
        {3'd0,1'b1,5'b00000,4'b0101,3'd0,3'd5,3'd0,3'd2,1'b1,4'd7,3'd5},
        {3'd0,1'b1,5'b00000,4'b1010,3'd4,3'd0,3'd4,3'd0,1'b1,4'd6,3'd4},
        {3'd3,1'b1,5'b00000,4'b0001,3'd0,3'd0,3'd0,3'd3,1'b0,4'd0,3'd3},
        {3'd3,1'b1,5'b00000,4'b0001,3'd0,3'd0,3'd0,3'd4,1'b1,4'd5,3'd4},
        {3'd0,1'b0,5'b00000,4'b0001,3'd0,3'd0,3'd0,3'd7,1'b0,4'd0,3'd0},
        {3'd7,1'b0,5'b00100,4'b0000,3'd0,3'd0,3'd0,3'd0,1'b1,4'd2,3'd7},
        {3'd7,1'b0,5'b01100,4'b0000,3'd0,3'd0,3'd0,3'd0,1'b1,4'd1,3'd7},
        {3'd0,1'b1,5'b11000,4'b0001,3'd0,3'd0,3'd0,3'd7,1'b1,4'd0,3'd0},
        {3'd0,1'b1,5'b00011,4'b0000,3'd0,3'd0,3'd0,3'd0,1'b1,4'd3,3'd7},
        {3'd0,1'b1,5'b00001,4'b0100,3'd0,3'd1,3'd0,3'd0,1'b1,4'd7,3'd1},
        {3'd0,1'b1,5'b00000,4'b0010,3'd0,3'd0,3'd0,3'd0,1'b0,4'd0,3'd0},
        {3'd7,1'b1,5'b00010,4'b0000,3'd0,3'd0,3'd0,3'd0,1'b1,4'd3,3'd7},
        {3'd0,1'b0,5'b00001,4'b0000,3'd0,3'd0,3'd0,3'd0,1'b0,4'd0,3'd0}
    };
    localparam string VEC_TAG [NVEC] = '{
        "R7","R3","R4","R5","R5","R5","R6","R2","R2","R2","R2","R11","R5","R5"
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {rst_irq, nmi_irq, wdt_irq, step_irq, amatch_irq} = '0;
        per_irq = '0;
        rti_load = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic restore(input logic [2:0] l, input logic e);
        rti_load = 1'b1;
        rti_ipl = l;
        rti_ien = e;
        @(negedge clk);
        rti_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R12 ack after reset", 32'(ack_valid), 0);
        check("R12 ipl after reset", 32'(ipl), 0);
        check("R12 ien after reset", 32'(ien), 0);

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            logic [32:0] v;
            v = VEC_TBL[k];
            do_reset();
            per_level = v[19:8];
            @(negedge clk);
            restore(v[32:30], v[29]);
            {rst_irq, nmi_irq, wdt_irq, step_irq, amatch_irq} = v[28:24];
            per_irq = v[23:20];
            @(negedge clk);
            {rst_irq, nmi_irq, wdt_irq, step_irq, amatch_irq} = '0;
            per_irq = '0;
            @(negedge clk);
            check($sformatf("%s vec%0d ack_valid", VEC_TAG[k], k), 32'(ack_valid), 32'(v[7]));
            if (v[7]) begin
                check($sformatf("%s vec%0d ack_src", VEC_TAG[k], k), 32'(ack_src), 32'(v[6:3]));
                check($sformatf("R7 vec%0d ack_vec", k), 32'(ack_vec), 32'h20 + 32'(v[6:3]));
            end
            @(negedge clk);
            check($sformatf("R7 vec%0d pulse ended", k), 32'(ack_valid), 0);
            check($sformatf("R8 vec%0d ipl", k), 32'(ipl), 32'(v[2:0]));
            check($sformatf("R8 vec%0d ien", k), 32'(ien), v[7] ? 0 : 32'(v[29]));
        end

        // R1 / R7: nmi and watchdog together, watchdog held then served after gap
        do_reset();
        restore(3'd7, 1'b0);
        nmi_irq = 1'b1; wdt_irq = 1'b1;
        @(negedge clk);
        nmi_irq = 1'b0; wdt_irq = 1'b0;
        @(negedge clk);
        check("R7 first ack nmi", 32'(ack_src), 1);
        @(negedge clk);
        check("R7 gap cycle 1", 32'(ack_valid), 0);
        @(negedge clk);
        check("R7 gap cycle 2", 32'(ack_valid), 0);
        @(negedge clk);
        check("R1 held watchdog ack", 32'(ack_valid), 1);
        check("R1 held watchdog src", 32'(ack_src), 2);

        // R9: refused by level, served after restore
        do_reset();
        per_level = {3'd0, 3'd0, 3'd0, 3'd3};
        restore(3'd5, 1'b1);
        per_irq = 4'b0001;
        @(negedge clk);
        per_irq = '0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R9 refused while ipl high", 32'(ack_valid), 0);
        end
        restore(3'd2, 1'b1);
        @(negedge clk);
        check("R9 served after restore valid", 32'(ack_valid), 1);
        check("R9 served after restore src", 32'(ack_src), 5);
        @(negedge clk);
        check("R9 ipl after serve", 32'(ipl), 3);

        // R4: older request at equal level beats lower index
        do_reset();
        per_level = {3'd0, 3'd0, 3'd3, 3'd3};
        restore(3'd0, 1'b0);
        per_irq = 4'b0010;
        @(negedge clk);
        per_irq = '0;
        repeat (2) @(negedge clk);
        per_irq = 4'b0001;
        @(negedge clk);
        per_irq = '0;
        @(negedge clk);
        restore(3'd0, 1'b1);
        @(negedge clk);
        check("R4 oldest wins", 32'(ack_src), 6);
        repeat (3) @(negedge clk);
        restore(3'd0, 1'b1);
        @(negedge clk);
        check("R4 younger served next", 32'(ack_src), 5);

        // R10: restore colliding with acknowledge edge, then plain restore
        do_reset();
        per_level = {3'd0, 3'd0, 3'd0, 3'd6};
        restore(3'd0, 1'b1);
        per_irq = 4'b0001;
        @(negedge clk);
        per_irq = '0;
        @(negedge clk);
        check("R10 ack present", 32'(ack_valid), 1);
        rti_load = 1'b1; rti_ipl = 3'd1; rti_ien = 1'b1;
        @(negedge clk);
        rti_load = 1'b0;
        check("R10 ack wins ipl", 32'(ipl), 6);
        check("R10 ack wins ien", 32'(ien), 0);
        restore(3'd4, 1'b1);
        check("R10 restore ipl", 32'(ipl), 4);
        check("R10 restore ien", 32'(ien), 1);

        // R12: reset drops pending request
        do_reset();
        per_level = {3'd0, 3'd0, 3'd0, 3'd2};
        restore(3'd0, 1'b0);
        per_irq = 4'b0001;
        @(negedge clk);
        per_irq = '0;
        do_reset();
        restore(3'd0, 1'b1);
        @(negedge clk);
        check("R12 pending cleared", 32'(ack_valid), 0);
        @(negedge clk);
        check("R12 pending cleared later", 32'(ack_valid), 0);

        // R11: request at level 0 not latched, raising level later has no effect
        do_reset();
        per_level = '0;
        restore(3'd0, 1'b0);
        per_irq = 4'b0010;
        @(negedge clk);
        per_irq = '0;
        per_level = {3'd0, 3'd0, 3'd5, 3'd0};
        restore(3'd0, 1'b1);
        @(negedge clk);
        check("R11 no ack after level raise", 32'(ack_valid), 0);
        @(negedge clk);
        check("R11 no ack later", 32'(ack_valid), 0);
        check("R11 ien untouched", 32'(ien), 1);

        finish_run();
    end
endmodule